// File: doc/BRIEF.md
# Program-Memory Banking with a Pattern-Borrowed Outer Bank

This block is the CPU-side program banking of a scanline-style cartridge mapper. The block holds three pieces of state: a bank-select register, eight 8-bit bank registers and a mode bit. From this state and the CPU address, it forms the 8 kB program bank number that goes to the ROMs.

The inner bank number is 6 bits wide, which covers 512 kB. Two more address bits, the outer bank, are taken from the top two bits of the character bank that the picture unit is currently fetching through. The outer bank is applied only to the lower half of the cartridge window. This lets up to 2 MB of program ROM be reached. The upper half of the window always stays in the first 512 kB.

The program space is spread over three ROMs, each split into a low and a high half. The block drives one active-low output enable for each ROM and an active-low chip-enable pair for the halves. It also raises an error flag when the borrowed outer value would enable two ROMs at once.

Top module: `prg_outer_bank_map`

## Requirements
- R1: After reset, all eight bank registers, the index and the mode bit are 0. A read of $8000 then gives bank 0x00, and a read of $C000 gives bank 0x3E.
- R2: A write with rom_sel_n=0 and CPU A14:A13=00 loads the bank-select register when CPU A0=0: bits 2:0 become the index and bit 6 becomes the mode. The same write with A0=1 loads the indexed bank register with all 8 data bits. Reads, writes with A14:A13 other than 00, and writes with rom_sel_n=1 change nothing.
- R3: In $8000-$9FFF, the inner bank is bits 5:0 of register 6 when the mode is 0, and 0x3E when the mode is 1.
- R4: In $A000-$BFFF, the inner bank is bits 5:0 of register 7.
- R5: In $C000-$DFFF, the inner bank is 0x3E when the mode is 0 and bits 5:0 of register 6 when the mode is 1. The outer bank is 0 here.
- R6: In $E000-$FFFF, the inner bank is 0x3F and the outer bank is 0.
- R7: For A14=0, the outer bank is bits 7:6 of the character register chosen by pattern address bits 12:10. Slots 0-1 choose register 0, slots 2-3 choose register 1, and slots 4-7 choose registers 2-5. prg_addr is {outer[1:0], inner[5:0]}.
- R8: rom_oe_n bit 0 (first ROM) is low when A14=1 or the outer bank is 00. For A14=0, bit 2 (third ROM) is low when outer bit 0 is set, and bit 1 (second ROM) is low when outer bit 1 is set.
- R9: ce_lo_n equals prg_addr bit 5 and ce_hi_n is its complement.
- R10: outer_err is 1 exactly when A14=0 and the outer bank is 11.
- R11: Changing bits 7:6 of any character register never changes the mapping of $C000-$FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes are captured on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_sel_n | input | 1 | Active-low cartridge window select ($8000-$FFFF) |
| ppu_addr | input | 14 | Current pattern fetch address |
| prg_addr | output | 8 | Program bank number {outer, inner} (address bits 20:13) |
| rom_oe_n | output | 3 | Active-low output enables for ROM 0, 1, 2 |
| ce_lo_n | output | 1 | Active-low enable for the low ROM half |
| ce_hi_n | output | 1 | Active-low enable for the high ROM half |
| outer_err | output | 1 | Outer value 11 would enable two ROMs |

## Verification
The assertions rely on three conditions on the inputs:
- A register write is a strobe that lasts one clock cycle.
- cpu_addr and ppu_addr are held steady between edges.
- rom_sel_n is the complement of CPU A15.

The stimulus changes every input only on the falling clock edge. It holds cpu_rw low for exactly one rising edge per write, and it always derives rom_sel_n from the address it drives. The random writes also go to $A000-$FFFF and $4000-$7FFF, so the ignored cases are exercised as well as the real register loads.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
    parameter int unsigned REG_W    = 8;
    parameter int unsigned NUM_REGS = 8;
    parameter int unsigned NUM_CHR  = 6;
    parameter int unsigned INNER_W  = 6;
    parameter int unsigned OUTER_W  = 2;
    parameter int unsigned NUM_ROMS = 3;
    parameter int unsigned MODE_BIT = 6;
    parameter int unsigned SLOT_W   = 3;
    localparam int unsigned IDX_W   = $clog2(NUM_REGS);
    localparam int unsigned PRG_W   = INNER_W + OUTER_W;

    typedef struct packed {
        logic [IDX_W-1:0]                 idx;
        logic                             mode;
        logic [NUM_REGS-1:0][REG_W-1:0]   bank;
    } map_state_t;
endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
    import prg_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_is_sel,
    input  logic [REG_W-1:0] wr_data,
    output map_state_t       st_q
);
    map_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_is_sel) begin
                st_d.idx  = wr_data[IDX_W-1:0];
                st_d.mode = wr_data[MODE_BIT];
            end else begin
                st_d.bank[st_q.idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/prg_chr_outer.sv
module prg_chr_outer
    import prg_map_pkg::*;
#(
    parameter int unsigned N_CHR = NUM_CHR,
    parameter int unsigned OW    = OUTER_W,
    parameter int unsigned SW    = SLOT_W
) (
    input  logic [N_CHR-1:0][OW-1:0] chr_hi,
    input  logic [SW-1:0]            slot,
    output logic [OW-1:0]            outer
);
    localparam int unsigned RI_W = $clog2(N_CHR);
    logic [RI_W-1:0] ri_d;

    // slots 0-1 and 2-3 are 2 kB pairs, 4-7 are single 1 kB banks
    always_comb begin
        if (slot < SW'(2))      ri_d = '0;
        else if (slot < SW'(4)) ri_d = RI_W'(1);
        else                    ri_d = RI_W'(slot - SW'(2));
        outer = chr_hi[ri_d];
    end
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_map_pkg::*;
#(
    parameter int unsigned IW = INNER_W,
    parameter int unsigned OW = OUTER_W
) (
    input  logic [1:0]     win,
    input  logic           mode,
    input  logic [IW-1:0]  sw_lo,
    input  logic [IW-1:0]  sw_mid,
    input  logic [OW-1:0]  chr_outer,
    output logic [IW+OW-1:0] bank
);
    localparam logic [IW-1:0] LAST_BANK = '1;
    localparam logic [IW-1:0] PEN_BANK  = {{(IW-1){1'b1}}, 1'b0};

    logic [IW-1:0] inner_d;
    logic [OW-1:0] outer_d;

    always_comb begin
        outer_d = win[1] ? '0 : chr_outer;
        unique case (win)
            2'b00:   inner_d = mode ? PEN_BANK : sw_lo;
            2'b01:   inner_d = sw_mid;
            2'b10:   inner_d = mode ? sw_lo : PEN_BANK;
            default: inner_d = LAST_BANK;
        endcase
        bank = {outer_d, inner_d};
    end
endmodule

// File: rtl/prg_chip_decode.sv
module prg_chip_decode
    import prg_map_pkg::*;
#(
    parameter int unsigned OW  = OUTER_W,
    parameter int unsigned NR  = NUM_ROMS
) (
    input  logic          upper_win,
    input  logic [OW-1:0] chr_outer,
    input  logic          half_sel,
    output logic [NR-1:0] oe_n,
    output logic          ce_lo_n,
    output logic          ce_hi_n,
    output logic          err
);
    assign oe_n[0] = ~(upper_win | (chr_outer == '0));

    for (genvar k = 1; k < NR; k++) begin : g_rom
        assign oe_n[k] = ~(~upper_win & chr_outer[NR-1-k]);
    end

    assign ce_lo_n = half_sel;
    assign ce_hi_n = ~half_sel;
    assign err     = ~upper_win & (&chr_outer);
endmodule

// File: rtl/prg_outer_bank_map.sv
module prg_outer_bank_map
    import prg_map_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cpu_addr,
    input  logic [REG_W-1:0]    cpu_data,
    input  logic                cpu_rw,
    input  logic                rom_sel_n,
    input  logic [13:0]         ppu_addr,
    output logic [PRG_W-1:0]    prg_addr,
    output logic [NUM_ROMS-1:0] rom_oe_n,
    output logic                ce_lo_n,
    output logic                ce_hi_n,
    output logic                outer_err
);
    localparam int unsigned SLOT_LSB = 10;

    map_state_t                      st_q;
    logic                            wr_en;
    logic [NUM_CHR-1:0][OUTER_W-1:0] chr_hi;
    logic [OUTER_W-1:0]              chr_outer;
    logic                            unused_bits;

    assign wr_en = ~cpu_rw & ~rom_sel_n & ~cpu_addr[14] & ~cpu_addr[13];

    prg_map_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_is_sel (~cpu_addr[0]),
        .wr_data   (cpu_data),
        .st_q      (st_q)
    );

    for (genvar c = 0; c < NUM_CHR; c++) begin : g_chr
        assign chr_hi[c] = st_q.bank[c][REG_W-1 -: OUTER_W];
    end

    prg_chr_outer u_outer (
        .chr_hi (chr_hi),
        .slot   (ppu_addr[SLOT_LSB +: SLOT_W]),
        .outer  (chr_outer)
    );

    prg_window_map u_win (
        .win       (cpu_addr[14:13]),
        .mode      (st_q.mode),
        .sw_lo     (st_q.bank[6][INNER_W-1:0]),
        .sw_mid    (st_q.bank[7][INNER_W-1:0]),
        .chr_outer (chr_outer),
        .bank      (prg_addr)
    );

    prg_chip_decode u_dec (
        .upper_win (cpu_addr[14]),
        .chr_outer (chr_outer),
        .half_sel  (prg_addr[INNER_W-1]),
        .oe_n      (rom_oe_n),
        .ce_lo_n   (ce_lo_n),
        .ce_hi_n   (ce_hi_n),
        .err       (outer_err)
    );

    assign unused_bits = ^{st_q, cpu_addr, ppu_addr};
endmodule

// File: rtl/prg_outer_bank_map_chk.sv
module prg_outer_bank_map_chk
    import prg_map_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [15:0]         cpu_addr,
    input logic                cpu_rw,
    input logic [13:0]         ppu_addr,
    input logic [PRG_W-1:0]    prg_addr,
    input logic [NUM_ROMS-1:0] rom_oe_n,
    input logic                ce_lo_n,
    input logic                ce_hi_n,
    input logic                outer_err
);
    AST_CE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ce_lo_n != ce_hi_n); // R9
    AST_UPPER_OUTER0: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[14] |-> prg_addr[PRG_W-1 -: OUTER_W] == '0); // R5
    AST_TOP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> (prg_addr[INNER_W-1:0] == '1)); // R6
    AST_UPPER_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[14] |-> (rom_oe_n == 3'b110)); // R8
    AST_ERR_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        outer_err |-> (rom_oe_n[2:1] == 2'b00)); // R10
    AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_rw) && $stable(cpu_addr) && $stable(ppu_addr)) |-> $stable(prg_addr)); // R2
endmodule

bind prg_outer_bank_map prg_outer_bank_map_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rw    (cpu_rw),
    .ppu_addr  (ppu_addr),
    .prg_addr  (prg_addr),
    .rom_oe_n  (rom_oe_n),
    .ce_lo_n   (ce_lo_n),
    .ce_hi_n   (ce_hi_n),
    .outer_err (outer_err)
);

// File: tb/prg_outer_bank_map_test.sv
`timescale 1ns/100ps
module prg_outer_bank_map_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1;
    logic        rom_sel_n = 1;
    logic [13:0] ppu_addr = 14'h0000;
    logic [7:0]  prg_addr;
    logic [2:0]  rom_oe_n;
    logic        ce_lo_n, ce_hi_n, outer_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_bank [8];
    logic [2:0] m_idx;
    logic       m_mode;

    always #2.5 clk = ~clk;

    prg_outer_bank_map uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n), .ppu_addr(ppu_addr),
        .prg_addr(prg_addr), .rom_oe_n(rom_oe_n), .ce_lo_n(ce_lo_n),
        .ce_hi_n(ce_hi_n), .outer_err(outer_err)
    );

    function automatic logic [1:0] exp_chr(input logic [13:0] pa);
        logic [2:0] s = pa[12:10];
        int r = (s < 2) ? 0 : (s < 4) ? 1 : int'(s) - 2;
        return m_bank[r][7:6];
    endfunction

    function automatic logic [7:0] exp_prg(input logic [15:0] a, input logic [13:0] pa);
        logic [5:0] in;
        logic [1:0] o = a[14] ? 2'b00 : exp_chr(pa);
        case (a[14:13])
            2'b00:   in = m_mode ? 6'h3E : m_bank[6][5:0];
            2'b01:   in = m_bank[7][5:0];
            2'b10:   in = m_mode ? m_bank[6][5:0] : 6'h3E;
            default: in = 6'h3F;
        endcase
        return {o, in};
    endfunction

    function automatic logic [2:0] exp_oe(input logic [15:0] a, input logic [13:0] pa);
        logic [1:0] o = exp_chr(pa);
        if (a[14]) return 3'b110;
        return {~o[0], ~o[1], ~(o == 2'b00)};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = 0; rom_sel_n = sel_n;
        @(posedge clk);
        if (!sel_n && a[14:13] == 2'b00) begin
            if (!a[0]) begin m_idx = d[2:0]; m_mode = d[6]; end
            else m_bank[m_idx] = d;
        end
        @(negedge clk);
        cpu_rw = 1;
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [13:0] pa);
        logic [7:0] e;
        @(negedge clk);
        cpu_addr = a; rom_sel_n = ~a[15]; cpu_rw = 1; ppu_addr = pa;
        #1;
        e = exp_prg(a, pa);
        chk(req, prg_addr, e);
        chk("R8", rom_oe_n, exp_oe(a, pa));
        chk("R9", {ce_lo_n, ce_hi_n}, {e[5], ~e[5]});
        chk("R10", outer_err, (!a[14] && exp_chr(pa) == 2'b11));
    endtask

    task automatic set_reg(input int r, input logic [7:0] d);
        wr(16'h8000, {m_mode, 3'b000, 3'(r)} | 8'h00, 1'b0);
        wr(16'h8001, d, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) m_bank[i] = 8'h00;
        m_idx = 0; m_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        rd("R1", 16'h8000, 14'h0000);
        rd("R1", 16'hC000, 14'h0000);
        // R2 / R3 / R4: directed loads
        set_reg(6, 8'h15); set_reg(7, 8'h2A);
        rd("R3", 16'h8123, 14'h0000);
        rd("R4", 16'hA000, 14'h0000);
        // R2 ignored writes: upper window, rom_sel high, A14:A13 != 00
        wr(16'hA001, 8'h3F, 1'b0);
        wr(16'h0001, 8'h3F, 1'b1);
        wr(16'hC001, 8'h07, 1'b0);
        rd("R2", 16'h8000, 14'h0000);
        rd("R2", 16'hA000, 14'h0000);
        // R5 mode switch
        wr(16'h8000, 8'h46, 1'b0);
        rd("R5", 16'hC000, 14'h0000);
        rd("R3", 16'h8000, 14'h0000);
        rd("R6", 16'hE000, 14'h0000);
        // R7 per-slot outer, R10 both ROMs
        for (int r = 0; r < 6; r++) set_reg(r, 8'((r % 4) << 6) | 8'h05);
        for (int s = 0; s < 8; s++) rd("R7", 16'h8000, 14'(s << 10));
        for (int s = 0; s < 8; s++) rd("R7", 16'hA000, 14'(s << 10));
        // R11 upper window immune to character bits
        for (int r = 0; r < 6; r++) begin
            set_reg(r, 8'hC0);
            for (int s = 0; s < 8; s++) begin
                rd("R11", 16'hC000, 14'(s << 10));
                rd("R11", 16'hE000, 14'(s << 10));
            end
        end
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a = 16'($urandom);
            logic [7:0]  d = 8'($urandom);
            if (a[15]) wr(a, d, 1'b0);
            else       wr(a, d, 1'b1);
            rd("R7", 16'h8000 | 16'($urandom), 14'($urandom));
            rd("R5", 16'hC000 | 16'($urandom), 14'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule